// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

The block is a memory-mapped event timer. A 32-bit up-counter runs while a global run bit is set. Several comparator channels watch the counter. When the counter reaches a channel's compare value, that channel raises its status bit in a shared status register. It can also raise its own interrupt line, as a level or as a single-cycle pulse. A channel either fires once, or, if it is built with the periodic capability, adds a stored interval to its compare value on every match so that it fires again at a fixed rate.

Software reaches the block through a plain 32-bit register bus: a write strobe, a byte address and write data, with read data returned combinationally for the address presented. Read-only words describe the timer: vendor and revision identifiers, channel count, and tick length in femtoseconds. Loading a periodic channel is a two-write sequence guarded by a one-shot arming flag in the channel's configuration word.

Top module: `evt_timer_array`

## Requirements
- R1: After reset the counter is 0 and halted, the global config word reads 0, the status register reads 0, every interrupt line is low, and a channel config reads only its periodic-capability bit (bit 4).
- R2: Address 0x00 reads {VENDOR_ID[31:16], 3'b0, NUM_CH-1 in bits 12:8, REV_ID[7:0]}, address 0x04 reads the nonzero tick length PERIOD_FS, and writes to both are ignored.
- R3: The counter (address 0x10) advances by one each clock while bit 0 of the global config word (address 0x08) is set, holds while it is clear, and wraps from 0xFFFFFFFF to 0.
- R4: A write to the counter address loads the counter only while it is halted; while it runs the write is ignored.
- R5: Channel n (config at 0x20+16n, compare at 0x24+16n) matches when the running counter equals its compare value, and the match sets bit n of the status register (0x0C) whether or not its interrupt-enable bit (config bit 2) is set.
- R6: Writing a one to a status bit clears it and writing zero leaves it unchanged; a match in the same cycle as the clear leaves the bit set.
- R7: With config bit 1 set (level), the interrupt line is high while the status bit and enable are both set; with bit 1 clear (edge), the line pulses for one cycle, in the cycle after the match, when enabled.
- R8: A channel in periodic mode (config bit 3) adds its stored interval to its compare value on every match.
- R9: Setting the arming bit (config bit 6) makes the next compare write load the match time and clear the bit; compare writes to a periodic channel with the bit clear load the interval.
- R10: On a channel without the periodic capability, config bit 3 reads 0, compare writes load the match time directly, and the channel fires once with its compare value left unchanged.
- R11: The route field (config bits 13:9) and the 32-bit-mode bit (config bit 8) read back as written; config bits 5, 14 and 15 and global config bit 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
The bench sweeps match distance against reload interval on a periodic edge-mode channel and predicts every pulse cycle arithmetically. It catches a reload that adds the interval one cycle late or not at all, and an arming flag that fails to clear and swallows the interval write. A short match-distance sweep with the enable on and off checks that status is set either way while the line follows the enable, which exposes a status bit gated by enable. Directed cases cover a status clear that lands on the match cycle and would lose the event, a counter write that takes effect while running, a one-shot match across the 32-bit wrap, and a periodic request on a channel without the capability that still reloads.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int REG_W = 32;

    // global word offsets inside block 0 (16-byte block index 0)
    localparam int WOFS_IDENT  = 0;
    localparam int WOFS_TICK   = 1;
    localparam int WOFS_GCTL   = 2;
    localparam int WOFS_STATUS = 3;
    // counter lives at block 1, word 0; channels start at block 2
    localparam int BLK_COUNT   = 1;
    localparam int BLK_CHAN0   = 2;

    // channel config bit positions
    localparam int CB_LEVEL  = 1;
    localparam int CB_IE     = 2;
    localparam int CB_PER    = 3;
    localparam int CB_PERCAP = 4;
    localparam int CB_ARM    = 6;
    localparam int CB_M32    = 8;
    localparam int ROUTE_LSB = 9;
    localparam int ROUTE_W   = 5;

    typedef struct packed {
        logic               ie;
        logic               level;
        logic               periodic;
        logic               arm;
        logic               mode32;
        logic [ROUTE_W-1:0] route;
        logic [REG_W-1:0]   cmp;
        logic [REG_W-1:0]   intv;
        logic               sts;
        logic               pulse;
    } chan_st_t;

endpackage

// File: rtl/evt_main_count.sv
module evt_main_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] value
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (load) begin
            st_d.cnt = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> value == $past(value));  // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> value == $past(value) + CW'(1));  // R3
    AST_CNT_LOAD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && load) |=> value == $past(load_val));  // R4

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter bit PERIODIC_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [REG_W-1:0] count,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             sts_clr,
    output logic [REG_W-1:0] cfg_rd,
    output logic [REG_W-1:0] cmp_rd,
    output logic             sts,
    output logic             irq
);

    chan_st_t st_d, st_q;
    logic     match;

    assign match = tick && (count == st_q.cmp);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = match && st_q.ie && !st_q.level;

        if (cfg_we) begin
            st_d.level    = wdata[CB_LEVEL];
            st_d.ie       = wdata[CB_IE];
            st_d.periodic = wdata[CB_PER] & PERIODIC_OK;
            st_d.arm      = wdata[CB_ARM];
            st_d.mode32   = wdata[CB_M32];
            st_d.route    = wdata[ROUTE_LSB +: ROUTE_W];
        end

        if (match && st_q.periodic) begin
            st_d.cmp = st_q.cmp + st_q.intv;
        end

        if (cmp_we) begin
            if (st_q.arm) begin
                st_d.cmp = wdata;
                st_d.arm = 1'b0;
            end else if (st_q.periodic) begin
                st_d.intv = wdata;
            end else begin
                st_d.cmp = wdata;
            end
        end

        if (sts_clr) begin
            st_d.sts = 1'b0;
        end
        if (match) begin
            st_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rd                         = '0;
        cfg_rd[CB_LEVEL]               = st_q.level;
        cfg_rd[CB_IE]                  = st_q.ie;
        cfg_rd[CB_PER]                 = st_q.periodic;
        cfg_rd[CB_PERCAP]              = PERIODIC_OK;
        cfg_rd[CB_ARM]                 = st_q.arm;
        cfg_rd[CB_M32]                 = st_q.mode32;
        cfg_rd[ROUTE_LSB +: ROUTE_W]   = st_q.route;
    end

    assign cmp_rd = st_q.cmp;
    assign sts    = st_q.sts;
    assign irq    = st_q.level ? (st_q.sts && st_q.ie) : st_q.pulse;

    AST_MATCH_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> sts);  // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !match) |=> !sts);  // R6
    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.ie && !st_q.level && !cfg_we) |=> irq);  // R7
    AST_PERIODIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.periodic && !cmp_we) |=> cmp_rd == $past(st_q.cmp + st_q.intv));  // R8
    AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && st_q.arm) |=> (!st_q.arm && cmp_rd == $past(wdata)));  // R9

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter int          ADDR_W    = 8,
    parameter logic [15:0] VENDOR_ID = 16'h1D0F,
    parameter logic [7:0]  REV_ID    = 8'h02,
    parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NUM_CH-1:0]       wlow,
    input  logic [REG_W-1:0]        count,
    input  logic [NUM_CH*REG_W-1:0] ch_cfg,
    input  logic [NUM_CH*REG_W-1:0] ch_cmp,
    input  logic [NUM_CH-1:0]       ch_sts,
    output logic                    run,
    output logic                    cnt_load,
    output logic [NUM_CH-1:0]       cfg_we,
    output logic [NUM_CH-1:0]       cmp_we,
    output logic [NUM_CH-1:0]       sts_clr,
    output logic [REG_W-1:0]        rdata
);

    localparam int BLK_W = ADDR_W - 4;

    typedef struct packed {
        logic run;
    } gbl_st_t;

    gbl_st_t            st_d, st_q;
    logic [BLK_W-1:0]   blk;
    logic [1:0]         wsel;
    logic               aligned;
    logic               hit_gctl, hit_status, hit_count;
    logic [REG_W-1:0]   ident_word;

    assign blk     = addr[ADDR_W-1:4];
    assign wsel    = addr[3:2];
    assign aligned = (addr[1:0] == 2'b00);

    assign hit_gctl   = aligned && blk == '0 && wsel == 2'(WOFS_GCTL);
    assign hit_status = aligned && blk == '0 && wsel == 2'(WOFS_STATUS);
    assign hit_count  = aligned && blk == BLK_W'(BLK_COUNT) && wsel == 2'd0;

    assign ident_word = {VENDOR_ID, 3'b000, 5'(NUM_CH - 1), REV_ID};

    always_comb begin
        st_d = st_q;
        if (wr_en && hit_gctl) begin
            st_d.run = wlow[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = st_q.run;
    assign cnt_load = wr_en && hit_count;
    assign sts_clr  = (wr_en && hit_status) ? wlow : '0;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
            logic hit_blk;
            assign hit_blk   = aligned && blk == BLK_W'(BLK_CHAN0 + g);
            assign cfg_we[g] = wr_en && hit_blk && wsel == 2'd0;
            assign cmp_we[g] = wr_en && hit_blk && wsel == 2'd1;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (blk == '0) begin
                case (wsel)
                    2'(WOFS_IDENT):  rdata = ident_word;
                    2'(WOFS_TICK):   rdata = PERIOD_FS;
                    2'(WOFS_GCTL):   rdata = {{(REG_W-1){1'b0}}, st_q.run};
                    default:         rdata = {{(REG_W-NUM_CH){1'b0}}, ch_sts};
                endcase
            end else if (blk == BLK_W'(BLK_COUNT) && wsel == 2'd0) begin
                rdata = count;
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (blk == BLK_W'(BLK_CHAN0 + i)) begin
                        if (wsel == 2'd0) rdata = ch_cfg[i*REG_W +: REG_W];
                        if (wsel == 2'd1) rdata = ch_cmp[i*REG_W +: REG_W];
                    end
                end
            end
        end
    end

    AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_we, cmp_we, cnt_load}));  // R4
    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|sts_clr) |-> wr_en);  // R6

endmodule

// File: rtl/evt_timer_array.sv
module evt_timer_array
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH        = 3,
    parameter int          ADDR_W        = 8,
    parameter logic [15:0] VENDOR_ID     = 16'h1D0F,
    parameter logic [7:0]  REV_ID        = 8'h02,
    parameter logic [31:0] PERIOD_FS     = 32'd10_000_000,
    parameter logic [31:0] PERIODIC_MASK = 32'h0000_0005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic                    run;
    logic                    cnt_load;
    logic [REG_W-1:0]        count;
    logic [NUM_CH-1:0]       cfg_we, cmp_we, sts_clr, ch_sts;
    logic [NUM_CH*REG_W-1:0] ch_cfg, ch_cmp;

    evt_regfile #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .VENDOR_ID (VENDOR_ID),
        .REV_ID    (REV_ID),
        .PERIOD_FS (PERIOD_FS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wlow     (bus_wdata[NUM_CH-1:0]),
        .count    (count),
        .ch_cfg   (ch_cfg),
        .ch_cmp   (ch_cmp),
        .ch_sts   (ch_sts),
        .run      (run),
        .cnt_load (cnt_load),
        .cfg_we   (cfg_we),
        .cmp_we   (cmp_we),
        .sts_clr  (sts_clr),
        .rdata    (bus_rdata)
    );

    evt_main_count #(.CW(REG_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .value    (count)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            evt_channel #(.PERIODIC_OK(PERIODIC_MASK[g])) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (run),
                .count   (count),
                .cfg_we  (cfg_we[g]),
                .cmp_we  (cmp_we[g]),
                .wdata   (bus_wdata),
                .sts_clr (sts_clr[g]),
                .cfg_rd  (ch_cfg[g*REG_W +: REG_W]),
                .cmp_rd  (ch_cmp[g*REG_W +: REG_W]),
                .sts     (ch_sts[g]),
                .irq     (irq[g])
            );
        end
    endgenerate

endmodule

// File: tb/sim_evt_timer_array.sv
module sim_evt_timer_array;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;

    localparam logic [7:0] A_IDENT  = 8'h00;
    localparam logic [7:0] A_TICK   = 8'h04;
    localparam logic [7:0] A_GCTL   = 8'h08;
    localparam logic [7:0] A_STATUS = 8'h0C;
    localparam logic [7:0] A_COUNT  = 8'h10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    evt_timer_array #(
        .NUM_CH        (NCH),
        .ADDR_W        (8),
        .VENDOR_ID     (16'h1D0F),
        .REV_ID        (8'h02),
        .PERIOD_FS     (32'd10_000_000),
        .PERIODIC_MASK (32'h5)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] a_cfg(input int ch);
        return 8'(8'h20 + ch * 16);
    endfunction
    function automatic logic [7:0] a_cmp(input int ch);
        return 8'(8'h24 + ch * 16);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic halt_and_load(input logic [31:0] start);
        wr(A_GCTL, 32'd0);
        wr(A_COUNT, start);
        wr(A_STATUS, 32'h7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(A_GCTL, v);       check("R1 gctl", v, 32'h0);
        rd(A_STATUS, v);     check("R1 status", v, 32'h0);
        rd(A_COUNT, v);      check("R1 count", v, 32'h0);
        rd(a_cfg(0), v);     check("R1 cfg0", v, 32'h10);
        rd(a_cfg(1), v);     check("R1 cfg1", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 identity words, read-only
        rd(A_IDENT, v);      check("R2 ident", v, 32'h1D0F_0202);
        rd(A_TICK, v);       check("R2 tick", v, 32'd10_000_000);
        wr(A_IDENT, 32'h0);
        wr(A_TICK, 32'h0);
        rd(A_IDENT, v);      check("R2 ident ro", v, 32'h1D0F_0202);
        rd(A_TICK, v);       check("R2 tick ro", v, 32'd10_000_000);

        // R3 halted counter holds
        step(5);
        rd(A_COUNT, v);      check("R3 frozen", v, 32'h0);

        // R4 load while halted
        wr(A_COUNT, 32'd500);
        rd(A_COUNT, v);      check("R4 load halted", v, 32'd500);

        // R3 counting
        wr(A_GCTL, 32'd1);
        rd(A_COUNT, v);
        step(7);
        rd(A_COUNT, v2);     check("R3 advance", v2, v + 32'd7);

        // R4 write while running ignored
        rd(A_COUNT, v);
        wr(A_COUNT, 32'd5);
        rd(A_COUNT, v2);     check("R4 ignored while running", v2, v + 32'd1);

        // R11 global bit 1 reads zero
        wr(A_GCTL, 32'hFFFF_FFFF);
        rd(A_GCTL, v);       check("R11 gctl bits", v, 32'h1);

        // R3 halt freezes
        wr(A_GCTL, 32'd0);
        rd(A_COUNT, v);
        step(4);
        rd(A_COUNT, v2);     check("R3 halt", v2, v);

        // R11 config readback on both kinds of channel
        wr(a_cfg(1), 32'hFFFF_FFFF);
        rd(a_cfg(1), v);     check("R11 cfg1 readback", v, 32'h3F46);
        wr(a_cfg(0), 32'hFFFF_FFFF);
        rd(a_cfg(0), v);     check("R11 cfg0 readback", v, 32'h3F5E);
        wr(a_cfg(0), 32'h0);
        wr(a_cfg(1), 32'h0);

        // R5/R7 level mode, one-shot ch0, sweep distance and enable
        for (int d = 1; d <= 4; d++) begin
            for (int ie = 0; ie < 2; ie++) begin
                halt_and_load(32'd200);
                wr(a_cfg(0), ie ? 32'h6 : 32'h2);
                wr(a_cmp(0), 32'd200 + 32'(d));
                wr(A_GCTL, 32'd1);
                step(d);
                rd(A_STATUS, v);   check("R5 before match", v & 32'h1, 32'h0);
                step(1);
                rd(A_STATUS, v);   check("R5 status set", v & 32'h1, 32'h1);
                check("R7 level line", 32'(irq[0]), 32'(ie));
                step(2);
                check("R7 level held", 32'(irq[0]), 32'(ie));
            end
        end

        // R6 write-one-to-clear, zero ignored
        wr(A_GCTL, 32'd0);
        wr(A_STATUS, 32'h0);
        rd(A_STATUS, v);     check("R6 zero write", v & 32'h1, 32'h1);
        wr(A_STATUS, 32'h1);
        rd(A_STATUS, v);     check("R6 clear", v & 32'h1, 32'h0);
        check("R7 level drops", 32'(irq[0]), 32'h0);

        // R6 clear on the match cycle leaves the bit set
        halt_and_load(32'd300);
        wr(a_cfg(0), 32'h6);
        wr(a_cmp(0), 32'd303);
        wr(A_GCTL, 32'd1);
        step(3);
        wr(A_STATUS, 32'h1);   // lands on the match edge
        rd(A_STATUS, v);     check("R6 set wins", v & 32'h1, 32'h1);
        wr(A_STATUS, 32'h1);
        rd(A_STATUS, v);     check("R6 later clear", v & 32'h1, 32'h0);

        // R8/R9/R7 sweep: periodic edge channel 2
        for (int d = 1; d <= 5; d++) begin
            for (int p = 1; p <= 4; p++) begin
                halt_and_load(32'd1000);
                wr(a_cfg(2), 32'h4C);           // arm, periodic, enable, edge
                wr(a_cmp(2), 32'd1000 + 32'(d));
                rd(a_cfg(2), v);  check("R9 arm cleared", v & 32'h40, 32'h0);
                wr(a_cmp(2), 32'(p));
                rd(a_cmp(2), v);  check("R9 interval write keeps match", v, 32'd1000 + 32'(d));
                wr(A_STATUS, 32'h7);
                wr(A_GCTL, 32'd1);
                for (int k = 1; k <= 20; k++) begin
                    logic e;
                    step(1);
                    e = (k >= d + 1) && (((k - d - 1) % p) == 0);
                    check("R8 periodic pulse", 32'(irq[2]), 32'(e));
                end
            end
        end

        // R8 compare advanced after matches
        halt_and_load(32'd100);
        wr(a_cfg(0), 32'h4C);
        wr(a_cmp(0), 32'd104);
        wr(a_cmp(0), 32'd10);
        wr(A_GCTL, 32'd1);
        step(5);
        rd(a_cmp(0), v);     check("R8 compare advanced", v, 32'd114);
        step(10);
        rd(a_cmp(0), v);     check("R8 compare advanced twice", v, 32'd124);

        // R10 channel without periodic capability, match across wrap
        halt_and_load(32'hFFFF_FFFE);
        wr(a_cfg(1), 32'h0C);           // periodic request, enable, edge
        rd(a_cfg(1), v);     check("R10 periodic bit reads 0", v, 32'h04);
        wr(a_cmp(1), 32'd0);
        wr(a_cmp(1), 32'd0);
        wr(A_GCTL, 32'd1);
        step(2);
        rd(A_COUNT, v);      check("R3 wrap", v, 32'd0);
        check("R10 no pulse yet", 32'(irq[1]), 32'h0);
        step(1);
        check("R10 one-shot pulse", 32'(irq[1]), 32'h1);
        rd(A_STATUS, v);     check("R5 wrap status", v & 32'h2, 32'h2);
        rd(a_cmp(1), v);     check("R10 compare unchanged", v, 32'd0);
        step(1);
        check("R7 pulse one cycle", 32'(irq[1]), 32'h0);
        step(10);
        check("R10 no refire", 32'(irq[1]), 32'h0);

        wr(A_GCTL, 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule